// File: doc/BRIEF.md
# Nonvolatile Data Store Access Controller

This block sits between a simple CPU register bus and a small nonvolatile data array, modelled here as a plain register array. Software sees three registers: a cell address, a data byte and a control register. Reads from the array are immediate, with a fixed CPU stall. Writes are guarded by a two-step unlock. Software first sets an arming bit, which lasts only a short window. Inside that window it sets a go bit to start the write.

A write runs for a fixed number of ticks of a separate timing oscillator. The core clock does not time it. While the write runs, the go bit reads as one and acts as the busy status. The address register and the data register are frozen for that time. When the last tick arrives, the array cell is updated and a one-cycle done pulse is raised. Starting a read or a write raises a stall output for a fixed number of core clocks. The two lengths differ. The CPU must treat this output as back-pressure and issue no further register access while it is high. The register bus itself has no handshake.

Top module: `nvm_access_unit`

## Requirements
- R1: After reset, the address, data and control registers read as zero, and both `cpu_stall` and `wr_done` are low.
- R2: A bus write with `reg_sel`=0 loads the address register and a bus write with `reg_sel`=1 loads the data register. Either register can be read back through `reg_rdata` with the same select.
- R3: The control register is `reg_sel`=2, with bit 0 = arm, bit 1 = go (busy) and bit 2 = read strobe. The read strobe always reads as 0. Arm becomes 1 only from a control write that has bit 0 set and bit 1 clear. A control write with both bits set leaves arm at 0.
- R4: Once set, arm reads as 1 for exactly four core clock cycles after the write edge and then clears by itself.
- R5: A control write with go set while arm is 0 has no effect: busy stays 0, no stall is raised and the array is not changed.
- R6: A control write with go set while arm is 1 and no write is busy starts a write. Busy reads 1 from the next cycle, arm clears, and `cpu_stall` is high for exactly two cycles.
- R7: A write stays busy until the WR_TICKS-th `osc_tick` pulse after its start (8 by default). On that pulse busy clears and `wr_done` is high for exactly one cycle.
- R8: At the end of a write, the array cell at the address register takes the value of the data register. A later read of that address returns the value.
- R9: A control write with the read strobe set, while no write is busy, loads the data register from the array cell at the address register and holds `cpu_stall` high for exactly four cycles.
- R10: A read strobe issued while a write is busy is ignored. The data register keeps its value and no stall is raised.
- R11: Bus writes to the address or data register while a write is busy are ignored, and the running write commits the values held at its start.
- R12: A go request made after the arm window has expired starts no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse from the write timing oscillator, already in the core clock domain |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read-back of the selected register (combinational) |
| cpu_stall | output | 1 | High while the CPU must hold its next instruction |
| wr_done | output | 1 | One-cycle pulse when a timed write commits |

## Verification
The bench counts the exact stall lengths after a read and after a write. A design that swapped the two lengths, or counted one cycle too many, would fail those counts. It walks the arm window cycle by cycle and also tries arm with go set in the same write, so a window that is too short or too long, or an unlock that accepts both bits at once, would show up in the control readback. It issues timer ticks one at a time and checks that busy holds through the second-to-last tick and ends on the last one. A design that counted core clocks, or that was off by one tick, would end the write at the wrong point. Reads, address writes and data writes issued during a busy write must leave the registers and the committed cell unchanged. A design that let any of them through would return the wrong data afterwards.

// File: rtl/nvm_pkg.sv
`timescale 1ns/1ps
package nvm_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CTL_ARM = 0;
  localparam int CTL_GO  = 1;
  localparam int CTL_RD  = 2;
endpackage

// File: rtl/nvm_unlock.sv
`timescale 1ns/1ps
module nvm_unlock #(
  parameter int ARM_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic arm_bit,
  input  logic go_bit,
  input  logic consume,
  output logic armed
);
  localparam int CW = $clog2(ARM_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          arm_req;

  assign arm_req = ctrl_wr && arm_bit && !go_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (consume) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (arm_req) begin
      armed <= 1'b1;
      cnt   <= CW'(ARM_CYCLES - 1);
    end else if (armed) begin
      if (cnt == '0) armed <= 1'b0;
      else           cnt   <= cnt - 1'b1;
    end
  end

  // R3: go written together with arm never opens the window
  a_r3_no_arm_with_go: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && go_bit && !armed) |=> !armed);

  // R4: window closes once its count is spent
  a_r4_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cnt == '0 && !arm_req) |=> !armed);
endmodule

// File: rtl/nvm_wr_timer.sv
`timescale 1ns/1ps
module nvm_wr_timer #(
  parameter int WR_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic finish,
  output logic done
);
  localparam int TW = $clog2(WR_TICKS + 1);

  logic [TW-1:0] tcnt;

  assign finish = busy && tick && (tcnt == TW'(WR_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tcnt <= '0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (start && !busy) begin
        busy <= 1'b1;
        tcnt <= '0;
      end else if (finish) begin
        busy <= 1'b0;
        tcnt <= '0;
      end else if (busy && tick) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R7: done follows the end of a busy period and lasts one cycle
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: without a tick a write cannot end
  a_r7_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);
endmodule

// File: rtl/nvm_stall.sv
`timescale 1ns/1ps
module nvm_stall #(
  parameter int RD_STALL = 4,
  parameter int WR_STALL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_start,
  input  logic wr_start,
  output logic stall
);
  localparam int MAXL = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int SW   = $clog2(MAXL + 1);

  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (wr_start)     cnt <= SW'(WR_STALL);
    else if (rd_start)     cnt <= SW'(RD_STALL);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign stall = (cnt != '0);

  // R6 / R9: an access start stalls the next cycle
  a_r6_start_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start || rd_start) |=> stall);
  // R9: the stall ends when its count runs out
  a_r9_stall_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == SW'(1) && !rd_start && !wr_start) |=> !stall);
endmodule

// File: rtl/nvm_cells.sv
`timescale 1ns/1ps
module nvm_cells #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nvm_access_unit.sv
`timescale 1ns/1ps
module nvm_access_unit
  import nvm_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int WR_TICKS   = 8,
  parameter int ARM_CYCLES = 4,
  parameter int RD_STALL   = 4,
  parameter int WR_STALL   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cpu_stall,
  output logic              wr_done
);
  logic              ctrl_wr, addr_wr, data_wr;
  logic              armed, busy, finish;
  logic              wr_start, rd_start;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, cell_rd;

  assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
  assign addr_wr  = reg_wr && (reg_sel == SEL_ADDR) && !busy;
  assign data_wr  = reg_wr && (reg_sel == SEL_DATA) && !busy;
  assign wr_start = ctrl_wr && reg_wdata[CTL_GO] && armed && !busy;
  assign rd_start = ctrl_wr && reg_wdata[CTL_RD] && !busy && !wr_start;

  nvm_unlock #(.ARM_CYCLES(ARM_CYCLES)) u_unlock (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .arm_bit(reg_wdata[CTL_ARM]), .go_bit(reg_wdata[CTL_GO]),
    .consume(wr_start), .armed(armed)
  );

  nvm_wr_timer #(.WR_TICKS(WR_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .tick(osc_tick),
    .busy(busy), .finish(finish), .done(wr_done)
  );

  nvm_stall #(.RD_STALL(RD_STALL), .WR_STALL(WR_STALL)) u_stall (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .wr_start(wr_start),
    .stall(cpu_stall)
  );

  nvm_cells #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .we(finish), .waddr(addr_q), .wdata(data_q),
    .raddr(addr_q), .rdata(cell_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (addr_wr) addr_q <= reg_wdata[ADDR_W-1:0];
      if (rd_start)     data_q <= cell_rd;
      else if (data_wr) data_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ADDR: reg_rdata = DATA_W'(addr_q);
      SEL_DATA: reg_rdata = data_q;
      SEL_CTRL: begin
        reg_rdata[CTL_ARM] = armed;
        reg_rdata[CTL_GO]  = busy;
      end
      default:  reg_rdata = '0;
    endcase
  end

  // R5: a write only begins from an armed state
  a_r5_start_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));
  // R10: data register frozen while busy
  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(data_q));
  // R11: address register frozen while busy
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q));
endmodule

// File: tb/nvm_access_unit_tb_top.sv
`timescale 1ns/1ps
module nvm_access_unit_tb_top;
  localparam int WR_TICKS = 8;
  localparam logic [7:0] ARM = 8'h01, GO = 8'h02, RD = 8'h04;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd3;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cpu_stall, wr_done;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nvm_access_unit #(.ADDR_W(6), .DATA_W(8), .WR_TICKS(WR_TICKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_stall(cpu_stall), .wr_done(wr_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [7:0] val);
    reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] val);
    reg_sel = sel; #1; val = reg_rdata;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (cpu_stall && n < 20) begin n++; @(negedge clk); end
  endtask

  task automatic tick_once();
    osc_tick = 1'b1; @(posedge clk); @(negedge clk); osc_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [5:0] a, output logic [7:0] v);
    int n;
    reg_write(2'd0, {2'b00, a});
    reg_write(2'd2, RD);
    count_stall(n);
    peek(2'd1, v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(2'd0, v); chk("R1 addr", v, 0);
    peek(2'd1, v); chk("R1 data", v, 0);
    peek(2'd2, v); chk("R1 ctrl", v, 0);
    chk("R1 stall", cpu_stall, 0);
    chk("R1 done", wr_done, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    reg_write(2'd0, 8'h15); peek(2'd0, v); chk("R2 addr", v, 8'h15);
    reg_write(2'd1, 8'hC3); peek(2'd1, v); chk("R2 data", v, 8'hC3);
  endtask

  task automatic t_arm_with_go();
    logic [7:0] v;
    reg_write(2'd2, ARM | GO);
    peek(2'd2, v); chk("R3 arm+go no arm", v, 0);
    chk("R3 no stall", cpu_stall, 0);
  endtask

  task automatic t_arm_window();
    logic [7:0] v;
    reg_write(2'd2, ARM);
    for (int i = 0; i < 4; i++) begin
      peek(2'd2, v); chk($sformatf("R3 R4 arm cycle %0d", i + 1), v, 8'h01);
      @(negedge clk);
    end
    peek(2'd2, v); chk("R4 arm cleared", v, 0);
  endtask

  task automatic t_go_unarmed();
    logic [7:0] v;
    reg_write(2'd0, 8'h02); reg_write(2'd1, 8'h77);
    reg_write(2'd2, GO);
    chk("R5 no stall", cpu_stall, 0);
    peek(2'd2, v); chk("R5 not busy", v, 0);
    for (int i = 0; i < WR_TICKS; i++) tick_once();
    do_read(6'h02, v); chk("R5 cell untouched", v, 0);
  endtask

  task automatic t_write();
    logic [7:0] v; int n;
    reg_write(2'd0, 8'h09); reg_write(2'd1, 8'hA5);
    reg_write(2'd2, ARM);
    reg_write(2'd2, GO);
    peek(2'd2, v); chk("R6 busy set arm clear", v, 8'h02);
    count_stall(n); chk("R6 write stall length", n, 2);
    for (int i = 0; i < WR_TICKS - 1; i++) tick_once();
    peek(2'd2, v); chk("R7 still busy before last tick", v, 8'h02);
    chk("R7 no early done", wr_done, 0);
    tick_once();
    peek(2'd2, v); chk("R7 busy cleared", v, 0);
    chk("R7 done pulse", wr_done, 1);
    @(negedge clk); chk("R7 done one cycle", wr_done, 0);
    reg_write(2'd1, 8'h00);
    do_read(6'h09, v); chk("R8 committed value", v, 8'hA5);
  endtask

  task automatic t_read();
    logic [7:0] v; int n;
    reg_write(2'd0, 8'h09); reg_write(2'd1, 8'h11);
    reg_write(2'd2, RD);
    count_stall(n); chk("R9 read stall length", n, 4);
    peek(2'd1, v); chk("R9 read data", v, 8'hA5);
  endtask

  task automatic t_busy_ignores();
    logic [7:0] v;
    reg_write(2'd0, 8'h20); reg_write(2'd1, 8'h5A);
    reg_write(2'd2, ARM); reg_write(2'd2, GO);
    idle(3);
    reg_write(2'd2, RD);
    chk("R10 no read stall", cpu_stall, 0);
    peek(2'd1, v); chk("R10 data kept", v, 8'h5A);
    reg_write(2'd0, 8'h21); reg_write(2'd1, 8'hFF);
    peek(2'd0, v); chk("R11 addr kept", v, 8'h20);
    peek(2'd1, v); chk("R11 data kept", v, 8'h5A);
    for (int i = 0; i < WR_TICKS; i++) tick_once();
    do_read(6'h20, v); chk("R11 commit used held data", v, 8'h5A);
    do_read(6'h21, v); chk("R11 other cell untouched", v, 0);
  endtask

  task automatic t_expired();
    logic [7:0] v;
    reg_write(2'd0, 8'h30); reg_write(2'd1, 8'h66);
    reg_write(2'd2, ARM);
    idle(5);
    reg_write(2'd2, GO);
    chk("R12 no stall", cpu_stall, 0);
    peek(2'd2, v); chk("R12 not busy", v, 0);
    for (int i = 0; i < WR_TICKS; i++) tick_once();
    do_read(6'h30, v); chk("R12 cell untouched", v, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_regs();
    t_arm_with_go();
    t_arm_window();
    t_go_unarmed();
    t_write();
    t_read();
    t_busy_ignores();
    t_expired();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule